// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches a small set of external interrupt pins, up to eight. Each pin goes through a two-flop synchroniser and then a detector. The detector is set per pin to one of five senses: falling edge, rising edge, both edges, low level or high level. A detected event is recorded in a per-pin source bit. An edge event stays in the source bit until software clears it. A level source bit follows the pin while the pin is at its active level.

Each pin has a mask bit and a 4-bit priority field. A pending source raises that pin's interrupt output only when the pin is unmasked and its priority is nonzero. The block also drives one combined output, the OR of all gated pins, for a shared interrupt line.

Software reaches the block over a simple synchronous register bus with a write strobe and a combinational read port. The registers are:
- sense fields
- priority fields
- source register
- mask-set register (write-only)
- mask-clear register (write-only)
- an optional mode register whose bit 23 turns on the per-pin outputs

Top module: `extirq_ctrl`

## Requirements
- R1: A change on a pin reaches the source register on the third rising clock edge after the change, through two synchroniser stages and one detector stage.
- R2: The sense register (address 0) holds one SENSE_W-bit field per pin, with pin n at bits [32-(n+1)*SENSE_W +: SENSE_W] (pin 0 in the most significant field), and reads back what was written.
- R3: The priority register (address 1) holds a 4-bit field per pin, with pin n at bits [32-(n+1)*4 +: 4]. A zero field blocks that pin's output and any nonzero value lets it through.
- R4: The sense codes are 0 for falling edge, 1 for rising edge, 2 for low level, 3 for high level and 4 for both edges. Codes 5 and above detect nothing.
- R5: In an edge sense, a detected edge sets the pin's source bit, and the bit stays set until it is cleared, whatever the pin does afterwards.
- R6: In a level sense, the source bit follows whether the pin is at its active level, and clear writes have no effect while the level is active.
- R7: The source register (address 2) shows pin n at bit SRC_W-1-n. Writing 0 to a bit clears a latched edge event. Bits written as 1 keep their state, so writing all zeros clears every latched edge event.
- R8: Writing 1 to pin n's bit (bit SRC_W-1-n) at the mask-set address 3 masks pin n, and writing 1 at the mask-clear address 4 unmasks it. Bits written as 0 change nothing. Both addresses read as 0, and masking leaves the source register unchanged.
- R9: With the mode register present, bit 23 of address 5 enables the per-pin outputs. While the bit is 0 every per-pin output is low and the combined output still works. Without the register, the block behaves as if the bit were 1.
- R10: After reset, all sense fields, priorities, source bits and the mode bit are 0, and every pin is masked.
- R11: Pin n's output is high when its source bit is set, it is unmasked, its priority is nonzero and the mode bit is set. The combined output is the OR of source, unmask and nonzero priority over all pins, and does not depend on the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pin | output | NUM_PINS | Per-pin interrupt outputs |
| irq_any | output | 1 | OR-combined interrupt output |

## Verification
The bench builds the block with eight pins, 4-bit sense fields, an 8-bit source register and the mode register present. With these values the sense and priority registers are fully packed, so every field boundary is exercised. The 4-bit sense fields make the both-edges code and the undefined codes reachable. Having the mode register present makes it possible to observe the per-pin outputs held low while the combined output stays live.

// File: rtl/extirq_pkg.sv
// Package: shared constants, register addresses and sense codes for the
// external interrupt pin controller. Assumes a 32-bit register bus.
package extirq_pkg;
    localparam int REG_W    = 32;
    localparam int PRIO_W   = 4;
    localparam int MODE_BIT = 23;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRIO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SRC   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MSET  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MCLR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd5;

    typedef enum logic [3:0] {
        SNS_FALL = 4'd0,
        SNS_RISE = 4'd1,
        SNS_LOW  = 4'd2,
        SNS_HIGH = 4'd3,
        SNS_BOTH = 4'd4
    } sense_e;

    // Lowest bit of pin p's field when fields of width fw are packed from the top.
    function automatic int field_lsb(input int p, input int fw);
        return REG_W - (p + 1) * fw;
    endfunction
endpackage

// File: rtl/extirq_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pins.
// Assumes each pin is independent; no bus coherency is implied.
module extirq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Capture the pins, then re-register to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/extirq_detect.sv
// Module: per-pin event detector and source bit.
// Assumes pin_s is already synchronous. Edge senses latch until cleared;
// level senses make the source bit follow the active level.
module extirq_detect #(
    parameter int SENSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_s,
    input  logic [SENSE_W-1:0] sense,
    input  logic               clr_stb,
    input  logic               clr_keep,
    output logic               src_q
);
    import extirq_pkg::*;

    logic       prev_q;
    logic [3:0] code;
    logic       rise, fall;
    logic       edge_mode, level_mode, edge_hit, level_act;

    assign code = 4'(sense);
    assign rise = pin_s & ~prev_q;
    assign fall = ~pin_s & prev_q;

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    // Decode the sense code into edge/level behaviour (R4).
    always_comb begin
        edge_mode  = 1'b0;
        level_mode = 1'b0;
        edge_hit   = 1'b0;
        level_act  = 1'b0;
        case (code)
            SNS_FALL: begin edge_mode = 1'b1;  edge_hit  = fall;        end
            SNS_RISE: begin edge_mode = 1'b1;  edge_hit  = rise;        end
            SNS_BOTH: begin edge_mode = 1'b1;  edge_hit  = rise | fall; end
            SNS_LOW:  begin level_mode = 1'b1; level_act = ~pin_s;      end
            SNS_HIGH: begin level_mode = 1'b1; level_act = pin_s;       end
            default:  begin edge_mode = 1'b1;  edge_hit  = 1'b0;        end
        endcase
    end

    // Update the source bit: level follows, edge latches, zero-write clears (R5, R6, R7).
    always_ff @(posedge clk) begin
        if (!rst_n)                      src_q <= 1'b0;
        else if (level_mode)             src_q <= level_act;
        else if (edge_hit)               src_q <= 1'b1;
        else if (clr_stb && !clr_keep)   src_q <= 1'b0;
    end

    a_r5_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && edge_hit) |=> src_q);
    a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && src_q && !(clr_stb && !clr_keep)) |=> src_q);
    a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode |=> (src_q == $past(level_act)));
    a_r7_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && !edge_hit && clr_stb && !clr_keep) |=> !src_q);
endmodule

// File: rtl/extirq_regs.sv
// Module: register file for sense, priority, masks and mode, plus the
// combinational read mux. Assumes NUM_PINS*SENSE_W and NUM_PINS*4 fit 32 bits
// and NUM_PINS <= SRC_W.
module extirq_regs #(
    parameter int NUM_PINS     = 8,
    parameter int SENSE_W      = 4,
    parameter int SRC_W        = 8,
    parameter bit HAS_MODE_REG = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [extirq_pkg::ADDR_W-1:0]     bus_addr,
    input  logic [extirq_pkg::REG_W-1:0]      bus_wdata,
    input  logic [NUM_PINS-1:0]               src_vec,
    output logic [extirq_pkg::REG_W-1:0]      bus_rdata,
    output logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_fld,
    output logic [NUM_PINS-1:0]               prio_nz,
    output logic [NUM_PINS-1:0]               mask_q,
    output logic                              indiv_en,
    output logic                              clr_stb,
    output logic [NUM_PINS-1:0]               clr_keep
);
    import extirq_pkg::*;

    logic [NUM_PINS-1:0][PRIO_W-1:0] prio_fld;
    logic wr_sense, wr_prio, wr_src, wr_mset, wr_mclr, wr_mode;

    assign wr_sense = bus_wr && (bus_addr == A_SENSE);
    assign wr_prio  = bus_wr && (bus_addr == A_PRIO);
    assign wr_src   = bus_wr && (bus_addr == A_SRC);
    assign wr_mset  = bus_wr && (bus_addr == A_MSET);
    assign wr_mclr  = bus_wr && (bus_addr == A_MCLR);
    assign wr_mode  = bus_wr && (bus_addr == A_MODE);

    // Store the per-pin sense fields, pin 0 in the top field (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) sense_fld <= '0;
        else if (wr_sense)
            for (int n = 0; n < NUM_PINS; n++)
                sense_fld[n] <= bus_wdata[field_lsb(n, SENSE_W) +: SENSE_W];
    end

    // Store the per-pin priority nibbles, pin 0 in the top nibble (R3).
    always_ff @(posedge clk) begin
        if (!rst_n) prio_fld <= '0;
        else if (wr_prio)
            for (int n = 0; n < NUM_PINS; n++)
                prio_fld[n] <= bus_wdata[field_lsb(n, PRIO_W) +: PRIO_W];
    end

    // Set or clear mask bits; zero bits leave the mask alone (R8, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else
            for (int n = 0; n < NUM_PINS; n++) begin
                if (wr_mset && bus_wdata[SRC_W-1-n]) mask_q[n] <= 1'b1;
                if (wr_mclr && bus_wdata[SRC_W-1-n]) mask_q[n] <= 1'b0;
            end
    end

    // Reduce each priority nibble to a pass/block gate.
    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) prio_nz[n] = |prio_fld[n];
    end

    // Map the source-clear write onto per-pin keep bits (R7).
    always_comb begin
        clr_stb = wr_src;
        for (int n = 0; n < NUM_PINS; n++) clr_keep[n] = bus_wdata[SRC_W-1-n];
    end

    // Mode register is built only when the parameter asks for it (R9).
    generate
        if (HAS_MODE_REG) begin : g_mode
            logic mode_q;
            // Hold the per-pin output enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n)       mode_q <= 1'b0;
                else if (wr_mode) mode_q <= bus_wdata[MODE_BIT];
            end
            assign indiv_en = mode_q;
        end else begin : g_nomode
            assign indiv_en = 1'b1;
        end
    endgenerate

    // Drive the read data for the addressed register; write-only ones read 0.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_SENSE: for (int n = 0; n < NUM_PINS; n++)
                         bus_rdata[field_lsb(n, SENSE_W) +: SENSE_W] = sense_fld[n];
            A_PRIO:  for (int n = 0; n < NUM_PINS; n++)
                         bus_rdata[field_lsb(n, PRIO_W) +: PRIO_W] = prio_fld[n];
            A_SRC:   for (int n = 0; n < NUM_PINS; n++)
                         bus_rdata[SRC_W-1-n] = src_vec[n];
            A_MODE:  bus_rdata[MODE_BIT] = HAS_MODE_REG ? indiv_en : 1'b0;
            default: bus_rdata = '0;
        endcase
    end

    a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mset && bus_wdata[SRC_W-1]) |=> mask_q[0]);
    a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mclr && bus_wdata[SRC_W-1]) |=> !mask_q[0]);
    a_r8_zero_noeffect: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_mset || wr_mclr) && !bus_wdata[SRC_W-1]) |=> $stable(mask_q[0]));
endmodule

// File: rtl/extirq_ctrl.sv
// Module: top of the external interrupt pin controller. Synchronises the
// pins, detects events per pin, gates them by mask, priority and mode, and
// drives per-pin and combined interrupt outputs.
module extirq_ctrl #(
    parameter int NUM_PINS     = 8,
    parameter int SENSE_W      = 4,
    parameter int SRC_W        = 8,
    parameter bit HAS_MODE_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_in,
    input  logic                 bus_wr,
    input  logic [2:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_PINS-1:0]  irq_pin,
    output logic                 irq_any
);
    logic [NUM_PINS-1:0]              pin_s;
    logic [NUM_PINS-1:0]              src_vec;
    logic [NUM_PINS-1:0][SENSE_W-1:0] sense_fld;
    logic [NUM_PINS-1:0]              prio_nz, mask_q, clr_keep;
    logic                             indiv_en, clr_stb;
    logic [NUM_PINS-1:0]              gated;

    extirq_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_s)
    );

    extirq_regs #(
        .NUM_PINS(NUM_PINS), .SENSE_W(SENSE_W),
        .SRC_W(SRC_W), .HAS_MODE_REG(HAS_MODE_REG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .src_vec(src_vec), .bus_rdata(bus_rdata),
        .sense_fld(sense_fld), .prio_nz(prio_nz), .mask_q(mask_q),
        .indiv_en(indiv_en), .clr_stb(clr_stb), .clr_keep(clr_keep)
    );

    generate
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
            extirq_detect #(.SENSE_W(SENSE_W)) u_det (
                .clk(clk), .rst_n(rst_n), .pin_s(pin_s[n]),
                .sense(sense_fld[n]), .clr_stb(clr_stb),
                .clr_keep(clr_keep[n]), .src_q(src_vec[n])
            );
            // R3: a zero priority never lets the pin through.
            a_r3_prio_gate: assert property (@(posedge clk) disable iff (!rst_n)
                !prio_nz[n] |-> !irq_pin[n]);
        end
    endgenerate

    // Combine source, mask and priority; mode gates only the per-pin outputs (R11).
    always_comb begin
        gated   = src_vec & ~mask_q & prio_nz;
        irq_pin = indiv_en ? gated : '0;
        irq_any = |gated;
    end

    a_r11_any_covers_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pin) |-> irq_any);
    a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !indiv_en |-> (irq_pin == '0));
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pin & mask_q) == '0));
endmodule

// File: tb/sim_extirq_ctrl.sv
// Bench: scoreboard of expected bus reads and outputs, compared by a monitor.
module sim_extirq_ctrl;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_pin;
    logic          irq_any;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0]   rd;
        logic [NP-1:0] pins;
        logic          any;
        string         tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    extirq_ctrl #(.NUM_PINS(NP), .SENSE_W(4), .SRC_W(8), .HAS_MODE_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin(irq_pin), .irq_any(irq_any)
    );

    // Monitor: pop each expected item at the falling edge and compare.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (bus_rdata !== e.rd || irq_pin !== e.pins || irq_any !== e.any) begin
                fails++;
                $display("FAIL %s: rdata=%h exp %h irq_pin=%h exp %h irq_any=%b exp %b",
                         e.tag, bus_rdata, e.rd, irq_pin, e.pins, irq_any, e.any);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic pins(input logic [NP-1:0] v, input int waitn);
        pin_in = v;
        tick(waitn);
    endtask

    // Driver side: push an expected item for the addressed read and the outputs.
    task automatic check(input logic [2:0] a, input logic [31:0] rd,
                         input logic [NP-1:0] p, input logic any, input string tag);
        exp_t e;
        bus_addr = a;
        e.rd = rd; e.pins = p; e.any = any; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10: reset state.
        check(3'd0, 32'h0, 8'h00, 1'b0, "R10 sense reset");
        check(3'd1, 32'h0, 8'h00, 1'b0, "R10 prio reset");
        check(3'd2, 32'h0, 8'h00, 1'b0, "R10 source reset");
        check(3'd5, 32'h0, 8'h00, 1'b0, "R10 mode reset");
        wr(3'd5, 32'h0080_0000);
        check(3'd5, 32'h0080_0000, 8'h00, 1'b0, "R9 mode readback");
        wr(3'd1, 32'hFFFF_FFFF);
        check(3'd1, 32'hFFFF_FFFF, 8'h00, 1'b0, "R3 prio readback");
        // R10 / R4: default falling sense latches, but pins start masked.
        pins(8'h01, 3);
        check(3'd2, 32'h0, 8'h00, 1'b0, "R4 rise ignored in falling mode");
        pins(8'h00, 3);
        check(3'd2, 32'h80, 8'h00, 1'b0, "R10 masked after reset, R4 falling");
        wr(3'd2, 32'h0);
        check(3'd2, 32'h0, 8'h00, 1'b0, "R7 all-zero clear");
        wr(3'd4, 32'hFF);
        check(3'd3, 32'h0, 8'h00, 1'b0, "R8 mask-set reads zero");
        check(3'd4, 32'h0, 8'h00, 1'b0, "R8 mask-clear reads zero");
        pins(8'h04, 3);
        wr(3'd0, 32'h1023_4111);
        tick(1);
        check(3'd0, 32'h1023_4111, 8'h00, 1'b0, "R2 sense readback");
        check(3'd2, 32'h0, 8'h00, 1'b0, "R6 inactive levels");
        // R1: rising on pin 0 shows on the third edge.
        pins(8'h05, 2);
        check(3'd2, 32'h0, 8'h00, 1'b0, "R1 not yet after two edges");
        tick(1);
        check(3'd2, 32'h80, 8'h01, 1'b1, "R1 visible on third edge");
        pins(8'h04, 3);
        check(3'd2, 32'h80, 8'h01, 1'b1, "R5 edge latch holds");
        pins(8'h06, 3);
        pins(8'h04, 3);
        check(3'd2, 32'hC0, 8'h03, 1'b1, "R7 pin1 at bit 6");
        wr(3'd2, 32'h7F);
        check(3'd2, 32'h40, 8'h02, 1'b1, "R7 zero clears, ones keep");
        // R6: low level on pin 2.
        pins(8'h00, 3);
        check(3'd2, 32'h60, 8'h06, 1'b1, "R6 low level sets");
        wr(3'd2, 32'h0);
        check(3'd2, 32'h20, 8'h04, 1'b1, "R6 clear ignored while active");
        pins(8'h04, 3);
        check(3'd2, 32'h0, 8'h00, 1'b0, "R6 follows level away");
        pins(8'h0C, 3);
        check(3'd2, 32'h10, 8'h08, 1'b1, "R6 high level");
        pins(8'h04, 3);
        check(3'd2, 32'h0, 8'h00, 1'b0, "R6 high level drops");
        // R4: both edges on pin 4.
        pins(8'h14, 3);
        check(3'd2, 32'h08, 8'h10, 1'b1, "R4 both edges rise");
        wr(3'd2, 32'h0);
        pins(8'h04, 3);
        check(3'd2, 32'h08, 8'h10, 1'b1, "R4 both edges fall");
        // R8: masking pin 4.
        wr(3'd3, 32'h08);
        check(3'd2, 32'h08, 8'h00, 1'b0, "R8 masked, source kept");
        wr(3'd4, 32'h08);
        check(3'd2, 32'h08, 8'h10, 1'b1, "R8 unmasked");
        wr(3'd3, 32'h00);
        check(3'd2, 32'h08, 8'h10, 1'b1, "R8 zero write no effect");
        // R3: zero priority on pin 4 (bits 15:12).
        wr(3'd1, 32'hFFFF_0FFF);
        check(3'd2, 32'h08, 8'h00, 1'b0, "R3 zero priority blocks");
        wr(3'd1, 32'hFFFF_FFFF);
        check(3'd2, 32'h08, 8'h10, 1'b1, "R11 priority restored");
        // R9: mode bit clear keeps combined output.
        wr(3'd5, 32'h0);
        check(3'd2, 32'h08, 8'h00, 1'b1, "R9 per-pin off, combined on");
        wr(3'd5, 32'h0080_0000);
        // R4: undefined code 7 on pin 5.
        wr(3'd0, 32'h1023_4711);
        pins(8'h24, 3);
        pins(8'h04, 3);
        check(3'd2, 32'h08, 8'h10, 1'b1, "R4 undefined code detects nothing");
        tick(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule